// File: doc/BRIEF.md
# Dual-Line Pulse Alternation Fault Monitor

This block watches two single-bit input lines, called line A and line B, and reports timing faults between them. Both lines are brought into the monitor clock through a synchronizer chain, and their rising and falling edges are found by comparing each new synchronized sample with the one before it. When the checked decoder mode is selected, the block checks four things. The two lines must take turns: each line must change level between two rises of the other. Opposite edges must not land on the same sample. The lines must never be high together.

Independently of the mode, each line has a saturating high-time counter. It measures how long the line has been high and compares the count against a programmable limit. Every fault sets a sticky flag. A small write-only register port loads the limit, the interrupt enables and the write-one-to-clear flag clears. The interrupt output rises only for a flag whose enable was already set when the flag became set. A flag that was set before its enable is written stays silent until it is cleared and set again.

Top module: `pulse_pair_monitor`

## Requirements
- R1: After reset all seven flags read 0, `irq` is 0, the enables are 0 and the limit holds its reset value (all ones by default).
- R2: With `mode_sel` = 1, two consecutive rises of line A with no level change of line B between them set flag bit 0. A level change of B in the same sample as the second A rise counts as between.
- R3: With `mode_sel` = 1, two consecutive rises of line B with no level change of line A between them set flag bit 1. Lines that alternate correctly with non-overlapping pulses set neither bit 0 nor bit 1.
- R4: With `mode_sel` = 1, a fall of one line and a rise of the other in the same synchronized sample set flag bit 2.
- R5: With `mode_sel` = 1, both synchronized lines high in the same sample set flag bit 3.
- R6: With `mode_sel` other than 1, flag bits 3..0 are never set. The alternation history is cleared, so checking restarts when mode 1 is selected again.
- R7: Each line has its own high-time counter. The counter clears while its line is low, counts up one per clock while the line is high, and saturates without wrapping. Flag bit 4 (line A) or bit 5 (line B) sets when that counter equals the limit while the line is high. This check runs in every mode.
- R8: A write with `wr_addr` = 0 loads the limit from `wr_data` and sets flag bit 6.
- R9: Flags are sticky. A write with `wr_addr` = 2 clears each flag whose `wr_data` bit is 1. When a clear and a new fault hit the same flag in the same cycle, the flag stays set.
- R10: A write with `wr_addr` = 1 loads the seven enable bits from `wr_data[6:0]`. `irq` is the OR of the flags that became set while their enable was already 1. A flag that was set before its enable was written does not drive `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_a | input | 1 | Input line A, asynchronous to `clk` |
| line_b | input | 1 | Input line B, asynchronous to `clk` |
| mode_sel | input | 2 | Decoder mode; the value 1 enables the alternation and overlap checks |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 2 | 0 = limit, 1 = enables, 2 = flag clear |
| wr_data | input | CNT_W | Write data |
| flags | output | 7 | Sticky fault flags, bits 0..6 as listed in the requirements |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `mode_sel` and the register port are synchronous to `clk`, and that `wr_en` is a single-cycle strobe carrying one address. They also assume that the lines are sampled only through the synchronizer, so that the edge and level signals they relate are a clean function of past samples. The bench drives every input on the falling clock edge and holds each line level for several cycles. Every transition therefore passes the synchronizer as a distinct edge. Each scenario that checks the alternation logic first leaves mode 1 for a few cycles, so that its expected flags do not depend on history left over from an earlier scenario.

// File: rtl/ppm_pkg.sv
package ppm_pkg;

   localparam int FLAG_N     = 7;
   localparam int F_B_MISS   = 0;
   localparam int F_A_MISS   = 1;
   localparam int F_EDGE     = 2;
   localparam int F_HIGH     = 3;
   localparam int F_A_LONG   = 4;
   localparam int F_B_LONG   = 5;
   localparam int F_LIMIT_WR = 6;

   localparam logic [1:0] MODE_CHECKED = 2'd1;

   typedef enum logic [1:0] {
      REG_LIMIT  = 2'd0,
      REG_ENABLE = 2'd1,
      REG_CLEAR  = 2'd2,
      REG_NONE   = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/ppm_line_sync.sv
module ppm_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic level,
   output logic rise,
   output logic fall
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ppm_line_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], raw};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign level = chain_q[STAGES-1];
   assign rise  = level & ~prev_q;
   assign fall  = ~level & prev_q;

endmodule

// File: rtl/ppm_pair_check.sv
module ppm_pair_check (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       active,
   input  logic [1:0] lvl,
   input  logic [1:0] rise,
   input  logic [1:0] fall,
   output logic [1:0] miss,
   output logic       edge_clash,
   output logic       high_clash
);

   for (genvar s = 0; s < 2; s++) begin : g_side
      localparam int O = 1 - s;
      logic seen_q;
      logic moved_q;
      logic other_edge;

      assign other_edge = rise[O] | fall[O];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            seen_q  <= 1'b0;
            moved_q <= 1'b0;
         end else if (!active) begin
            seen_q  <= 1'b0;
            moved_q <= 1'b0;
         end else if (rise[s]) begin
            seen_q  <= 1'b1;
            moved_q <= 1'b0;
         end else if (other_edge) begin
            moved_q <= 1'b1;
         end
      end

      assign miss[s] = active & rise[s] & seen_q & ~(moved_q | other_edge);

      // R6
      seen_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !active |=> !seen_q);
   end

   assign edge_clash = active & ((fall[0] & rise[1]) | (fall[1] & rise[0]));
   assign high_clash = active & lvl[0] & lvl[1];

endmodule

// File: rtl/ppm_high_timer.sv
module ppm_high_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             level,
   input  logic [CNT_W-1:0] limit,
   output logic             over
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("ppm_high_timer: CNT_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (!level)          cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
   end

   assign over = level && (cnt_q == limit);

   // R7
   cnt_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0) |-> $past(level));

   // R7
   cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (level && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/ppm_flag_bank.sv
module ppm_flag_bank #(
   parameter int N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   input  logic [N-1:0] en,
   output logic [N-1:0] flags,
   output logic         irq
);

   logic [N-1:0] flag_q, qual_q;
   logic [N-1:0] fresh, flag_n, qual_n;

   always_comb begin
      fresh  = set & (~flag_q | clr);
      flag_n = (flag_q & ~clr) | set;
      qual_n = flag_n & ((qual_q & ~clr) | (fresh & en));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= '0;
         qual_q <= '0;
      end else begin
         flag_q <= flag_n;
         qual_q <= qual_n;
      end
   end

   assign flags = flag_q;
   assign irq   = |(flag_q & qual_q);

   for (genvar i = 0; i < N; i++) begin : g_bit
      // R9
      sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_q[i] && !clr[i]) |=> flag_q[i]);
   end

   // R10
   irq_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> (($past(en) & flag_q) != '0));

endmodule

// File: rtl/pulse_pair_monitor.sv
module pulse_pair_monitor
   import ppm_pkg::*;
#(
   parameter int               CNT_W       = 16,
   parameter int               SYNC_STAGES = 2,
   parameter logic [CNT_W-1:0] RESET_LIMIT = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_a,
   input  logic              line_b,
   input  logic [1:0]        mode_sel,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   output logic [FLAG_N-1:0] flags,
   output logic              irq
);

   generate
      if (CNT_W < FLAG_N) begin : g_bad_data
         $error("pulse_pair_monitor: CNT_W must hold all flag bits");
      end
   endgenerate

   reg_sel_e          sel;
   logic [1:0]        raw, lvl, rise, fall, over, miss;
   logic              active, edge_clash, high_clash;
   logic [CNT_W-1:0]  limit_q;
   logic [FLAG_N-1:0] en_q, set_vec, clr_vec;
   logic              limit_wr;

   assign raw    = {line_b, line_a};
   assign active = (mode_sel == MODE_CHECKED);
   assign sel    = reg_sel_e'(wr_addr);

   for (genvar k = 0; k < 2; k++) begin : g_line
      ppm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk(clk), .rst_n(rst_n), .raw(raw[k]),
         .level(lvl[k]), .rise(rise[k]), .fall(fall[k]));

      ppm_high_timer #(.CNT_W(CNT_W)) u_timer (
         .clk(clk), .rst_n(rst_n), .level(lvl[k]),
         .limit(limit_q), .over(over[k]));
   end

   ppm_pair_check u_pair (
      .clk(clk), .rst_n(rst_n), .active(active),
      .lvl(lvl), .rise(rise), .fall(fall),
      .miss(miss), .edge_clash(edge_clash), .high_clash(high_clash));

   assign limit_wr = wr_en && (sel == REG_LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         limit_q <= RESET_LIMIT;
         en_q    <= '0;
      end else if (wr_en) begin
         if (sel == REG_LIMIT)  limit_q <= wr_data;
         if (sel == REG_ENABLE) en_q    <= wr_data[FLAG_N-1:0];
      end
   end

   always_comb begin
      set_vec             = '0;
      set_vec[F_B_MISS]   = miss[0];
      set_vec[F_A_MISS]   = miss[1];
      set_vec[F_EDGE]     = edge_clash;
      set_vec[F_HIGH]     = high_clash;
      set_vec[F_A_LONG]   = over[0];
      set_vec[F_B_LONG]   = over[1];
      set_vec[F_LIMIT_WR] = limit_wr;
      clr_vec = (wr_en && sel == REG_CLEAR) ? wr_data[FLAG_N-1:0] : '0;
   end

   ppm_flag_bank #(.N(FLAG_N)) u_flags (
      .clk(clk), .rst_n(rst_n), .set(set_vec), .clr(clr_vec),
      .en(en_q), .flags(flags), .irq(irq));

   // R6
   mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && flags[3:0] == 4'd0) |=> (flags[3:0] == 4'd0));

   // R8
   limit_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd0) |=> (flags[F_LIMIT_WR] && limit_q == $past(wr_data)));

endmodule

// File: tb/pulse_pair_monitor_bench.sv
`timescale 1ns/1ps
module pulse_pair_monitor_bench;

   localparam int CNT_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             line_a = 1'b0, line_b = 1'b0;
   logic [1:0]       mode_sel = 2'd0;
   logic             wr_en = 1'b0;
   logic [1:0]       wr_addr = 2'd0;
   logic [CNT_W-1:0] wr_data = '0;
   logic [6:0]       flags;
   logic             irq;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   pulse_pair_monitor #(.CNT_W(CNT_W)) u_pulse_pair_monitor (
      .clk(clk), .rst_n(rst_n), .line_a(line_a), .line_b(line_b),
      .mode_sel(mode_sel), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .flags(flags), .irq(irq));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [CNT_W-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic pulse(input bit on_b, input int hi, input int gap);
      @(negedge clk);
      if (on_b) line_b = 1'b1; else line_a = 1'b1;
      tick(hi);
      if (on_b) line_b = 1'b0; else line_a = 1'b0;
      tick(gap);
   endtask

   task automatic restart_checked;
      mode_sel = 2'd0;
      tick(4);
      reg_write(2'd2, 16'h007F);
      mode_sel = 2'd1;
      tick(2);
   endtask

   task automatic t_reset;
      check("R1 flags after reset", flags, 7'h00);
      check("R1 irq after reset", irq, 1'b0);
   endtask

   task automatic t_b_miss;
      restart_checked();
      pulse(1'b0, 3, 4);
      pulse(1'b0, 3, 6);
      check("R2 B missed between A rises", flags, 7'h01);
   endtask

   task automatic t_alternate;
      restart_checked();
      pulse(1'b0, 3, 4);
      pulse(1'b1, 3, 4);
      pulse(1'b0, 3, 4);
      pulse(1'b1, 3, 4);
      pulse(1'b0, 3, 6);
      check("R3 clean alternation raises nothing", flags, 7'h00);
   endtask

   task automatic t_a_miss;
      restart_checked();
      pulse(1'b1, 3, 4);
      pulse(1'b1, 3, 6);
      check("R3 A missed between B rises", flags, 7'h02);
   endtask

   task automatic t_high_overlap;
      restart_checked();
      @(negedge clk); line_a = 1'b1;
      tick(4);
      line_b = 1'b1;
      tick(5);
      check("R5 both high sets bit 3", flags[3], 1'b1);
      line_a = 1'b0;
      tick(4);
      line_b = 1'b0;
      tick(4);
   endtask

   task automatic t_edge_clash;
      restart_checked();
      @(negedge clk); line_a = 1'b1;
      tick(5);
      line_a = 1'b0; line_b = 1'b1;
      tick(5);
      check("R4 coincident opposite edges set bit 2", flags[2], 1'b1);
      check("R4 no high overlap on a clean swap", flags[3], 1'b0);
      line_b = 1'b0;
      tick(4);
   endtask

   task automatic t_mode_gate;
      mode_sel = 2'd0;
      tick(2);
      reg_write(2'd2, 16'h007F);
      mode_sel = 2'd2;
      pulse(1'b0, 3, 4);
      pulse(1'b0, 3, 4);
      @(negedge clk); line_a = 1'b1;
      tick(4);
      line_b = 1'b1;
      tick(4);
      line_b = 1'b0;
      tick(4);
      line_a = 1'b0; line_b = 1'b1;
      tick(4);
      line_b = 1'b0;
      tick(5);
      check("R6 checks idle outside mode 1", flags[3:0], 4'h0);
      mode_sel = 2'd0;
   endtask

   task automatic t_long;
      mode_sel = 2'd0;
      reg_write(2'd0, 16'd10);
      reg_write(2'd2, 16'h007F);
      pulse(1'b0, 6, 5);
      check("R7 short A pulse no overflow", flags, 7'h00);
      pulse(1'b0, 8, 3);
      pulse(1'b0, 8, 5);
      check("R7 counter clears between pulses", flags, 7'h00);
      pulse(1'b0, 20, 5);
      check("R7 long A pulse sets bit 4", flags, 7'h10);
      reg_write(2'd2, 16'h007F);
      pulse(1'b1, 20, 5);
      check("R7 long B pulse sets bit 5", flags, 7'h20);
      reg_write(2'd0, 16'hFFFF);
      reg_write(2'd2, 16'h007F);
   endtask

   task automatic t_limit_and_sticky;
      reg_write(2'd0, 16'hFFFF);
      check("R8 limit write sets bit 6", flags, 7'h40);
      tick(10);
      check("R9 flag holds with no clear", flags, 7'h40);
      reg_write(2'd2, 16'h0010);
      check("R9 clear of other bit leaves flag", flags, 7'h40);
      reg_write(2'd2, 16'h0040);
      check("R9 write-one clears flag", flags, 7'h00);
      restart_checked();
      @(negedge clk); line_a = 1'b1; line_b = 1'b1;
      tick(6);
      reg_write(2'd2, 16'h0008);
      check("R9 new event beats clear", flags[3], 1'b1);
      line_a = 1'b0; line_b = 1'b0;
      mode_sel = 2'd0;
      tick(5);
      reg_write(2'd2, 16'h007F);
   endtask

   task automatic t_irq;
      reg_write(2'd1, 16'h0000);
      reg_write(2'd2, 16'h007F);
      reg_write(2'd0, 16'hFFFF);
      check("R10 disabled flag gives no irq", irq, 1'b0);
      reg_write(2'd1, 16'h0040);
      tick(2);
      check("R10 flag set before enable stays silent", irq, 1'b0);
      reg_write(2'd2, 16'h0040);
      reg_write(2'd0, 16'hFFFF);
      check("R10 enabled flag raises irq", irq, 1'b1);
      reg_write(2'd2, 16'h0040);
      check("R10 clearing flag drops irq", irq, 1'b0);
      reg_write(2'd1, 16'h0000);
   endtask

   initial begin
      #(5.0 * 100000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      tick(3);
      t_reset();
      rst_n = 1'b1;
      tick(2);
      t_reset();
      t_b_miss();
      t_alternate();
      t_a_miss();
      t_high_overlap();
      t_edge_clash();
      t_mode_gate();
      t_long();
      t_limit_and_sticky();
      t_irq();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule